// File: doc/BRIEF.md
# SD Command Line Controller

This block drives one command exchange on the single-wire SD command line. Upstream logic presents a 6-bit command index, a 32-bit argument and a 2-bit reply-kind code, then pulses a start strobe. The block builds a 48-bit frame that ends in a CRC7 and shifts it out most significant bit first, one bit per clock. Depending on the reply kind, it then either finishes at once or listens on the line for a short (48-bit) or long (136-bit) reply from the card.

When a reply arrives, the block checks it, keeps the reply's 6-bit index field and up to 128 payload bits in four 32-bit words, and sets one sticky completion or error flag. Each flag stays set until a write-one-to-clear strobe on its bit removes it. While an exchange is in progress, a busy output stays high.

Top module: `sd_cmd_path`

## Requirements
- R1: The transmitted frame is: bit 0, bit 1, the 6-bit index, the 32-bit argument, CRC7 (polynomial x^7+x^3+1, over the first 40 bits), then bit 1. It is sent MSB first on `cmd_out`, with `cmd_oe` high for exactly 48 cycles. The first bit appears in the cycle after the clock edge that samples `cmd_start`. When `cmd_oe` is low, `cmd_out` idles at 1.
- R2: A `cmd_start` pulse while `busy` is high is ignored, and the frame in flight is unchanged.
- R3: Reply-kind codes 2'b00 and 2'b10 expect no reply. After the end bit, the block sets flag bit 0 (sent) and returns to idle without listening.
- R4: Code 2'b01 expects a 48-bit reply. If the CRC7 over its first 40 bits matches bits 7:1 and the end bit is 1, the block sets flag bit 1 (reply good). `resp_index` takes reply bits 45:40 and `resp_word0` takes bits 39:8, while words 1 to 3 read 0.
- R5: If a short reply fails the CRC7 compare, or has an end bit of 0, the block sets flag bit 2 (reply CRC fail) and not flag bit 1. The index field and payload are still stored.
- R6: Code 2'b11 expects a 136-bit reply. `resp_index` takes bits 133:128, and words 0 to 3 take bits 127:0, with word 0 the most significant. The block sets flag bit 1 when the end bit is 1 and flag bit 2 when it is 0. The internal CRC of the long reply is not checked.
- R7: After the end bit, the line is sampled for a 0 start bit for `TIMEOUT_CYC` (64) cycles. A start bit seen in the last of those cycles is still accepted. If none is seen, the block sets flag bit 3 (timeout).
- R8: `busy` rises in the cycle after an accepted start. It falls in the same cycle as the completion or error flag that ends the exchange is set.
- R9: Flags are sticky. A 1 on bit i of `flag_clr` clears flag i at the next edge. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R10: After reset, all flags are 0, `busy` and `cmd_oe` are 0, `cmd_out` is 1, and the reply index and words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, one line bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start strobe, taken only while idle |
| cmd_index | input | 6 | Command index to send |
| cmd_arg | input | 32 | Command argument |
| resp_kind | input | 2 | Reply kind: 00/10 none, 01 short, 11 long |
| flag_clr | input | 4 | Write-one-to-clear strobes, one per flag |
| cmd_in | input | 1 | Command line as seen from the card side |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Drive enable for the command line |
| busy | output | 1 | Exchange in progress |
| flags | output | 4 | Sticky flags: 0 sent, 1 reply good, 2 CRC fail, 3 timeout |
| resp_index | output | 6 | Index field of the last reply |
| resp_word0 | output | 32 | Reply payload, most significant word |
| resp_word1 | output | 32 | Reply payload word 1 |
| resp_word2 | output | 32 | Reply payload word 2 |
| resp_word3 | output | 32 | Reply payload, least significant word |

## Verification
Two functions can fall in the same cycle: the sticky-flag update and the software clear. The bench provokes this by timing a clear of the timeout flag to land on exactly the edge at which the 64th wait cycle expires. It judges the result by the flag still reading 1 afterwards. A related edge case is a reply start bit placed on that same last wait cycle, which must be taken as a reply rather than a timeout.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX} cmd_state_e;

    localparam int FRAME_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int NUM_FLAGS  = 4;

    localparam int FLG_SENT = 0;
    localparam int FLG_GOOD = 1;
    localparam int FLG_CRC  = 2;
    localparam int FLG_TMO  = 3;
endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7 #(
    parameter int NBITS = 40
) (
    input  logic [NBITS-1:0] data,
    output logic [6:0]       crc
);
    logic [6:0] acc;
    logic       fb;

    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = NBITS - 1; i >= 0; i--) begin
            fb  = data[i] ^ acc[6];
            acc = {acc[5:0], 1'b0};
            if (fb) acc = acc ^ 7'h09;
        end
        crc = acc;
    end
endmodule

// File: rtl/sd_cmd_flags.sv
module sd_cmd_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path
    import sd_cmd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic [1:0]  resp_kind,
    input  logic [3:0]  flag_clr,
    input  logic        cmd_in,
    output logic        cmd_out,
    output logic        cmd_oe,
    output logic        busy,
    output logic [3:0]  flags,
    output logic [5:0]  resp_index,
    output logic [31:0] resp_word0,
    output logic [31:0] resp_word1,
    output logic [31:0] resp_word2,
    output logic [31:0] resp_word3
);
    localparam int MAXCNT = (LONG_BITS > TIMEOUT_CYC) ? LONG_BITS : TIMEOUT_CYC;
    localparam int CNT_W  = $clog2(MAXCNT + 1);
    localparam int RX_W   = LONG_BITS - 1;
    localparam int BODY   = FRAME_BITS - 8;

    typedef struct packed {
        cmd_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [FRAME_BITS-1:0] tx;
        logic [RX_W-1:0]     rx;
        logic                want;
        logic                long_rsp;
        logic [5:0]          ridx;
        logic [127:0]        rwords;
    } ctl_t;

    ctl_t q, d;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [LONG_BITS-1:0] rx_full;
    logic [6:0]           tx_crc, rx_crc;
    logic [CNT_W-1:0]     last_bit;
    logic                 end_ok;

    assign rx_full  = {q.rx, cmd_in};
    assign last_bit = q.long_rsp ? CNT_W'(LONG_BITS - 1) : CNT_W'(FRAME_BITS - 1);
    assign end_ok   = rx_full[0];

    sd_cmd_crc7 #(.NBITS(BODY)) u_tx_crc (
        .data ({2'b01, cmd_index, cmd_arg}),
        .crc  (tx_crc)
    );

    sd_cmd_crc7 #(.NBITS(BODY)) u_rx_crc (
        .data (rx_full[FRAME_BITS-1:8]),
        .crc  (rx_crc)
    );

    always_comb begin
        d        = q;
        flag_set = '0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    d.st       = ST_TX;
                    d.cnt      = '0;
                    d.tx       = {2'b01, cmd_index, cmd_arg, tx_crc, 1'b1};
                    d.want     = resp_kind[0];
                    d.long_rsp = (resp_kind == 2'b11);
                end
            end
            ST_TX: begin
                d.tx  = {q.tx[FRAME_BITS-2:0], 1'b1};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                    d.cnt = '0;
                    if (q.want) begin
                        d.st = ST_WAIT;
                    end else begin
                        d.st = ST_IDLE;
                        flag_set[FLG_SENT] = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (!cmd_in) begin
                    d.st  = ST_RX;
                    d.rx  = rx_full[RX_W-1:0];
                    d.cnt = CNT_W'(1);
                end else if (q.cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
                    d.st = ST_IDLE;
                    flag_set[FLG_TMO] = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RX: begin
                d.rx  = rx_full[RX_W-1:0];
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == last_bit) begin
                    d.st = ST_IDLE;
                    if (q.long_rsp) begin
                        d.ridx   = rx_full[133:128];
                        d.rwords = rx_full[127:0];
                        flag_set[FLG_GOOD] = end_ok;
                        flag_set[FLG_CRC]  = !end_ok;
                    end else begin
                        d.ridx   = rx_full[45:40];
                        d.rwords = {rx_full[39:8], 96'b0};
                        flag_set[FLG_GOOD] = end_ok && (rx_crc == rx_full[7:1]);
                        flag_set[FLG_CRC]  = !(end_ok && (rx_crc == rx_full[7:1]));
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, tx: '1, default: '0};
        end else begin
            q <= d;
        end
    end

    sd_cmd_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flags)
    );

    assign cmd_oe     = (q.st == ST_TX);
    assign cmd_out    = cmd_oe ? q.tx[FRAME_BITS-1] : 1'b1;
    assign busy       = (q.st != ST_IDLE);
    assign resp_index = q.ridx;
    assign resp_word0 = q.rwords[127:96];
    assign resp_word1 = q.rwords[95:64];
    assign resp_word2 = q.rwords[63:32];
    assign resp_word3 = q.rwords[31:0];
endmodule

// File: rtl/sd_cmd_path_chk.sv
module sd_cmd_path_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       busy,
    input logic       cmd_oe,
    input logic       cmd_out,
    input logic [3:0] flags,
    input logic [3:0] flag_clr,
    input logic [3:0] flag_set
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out) else $error("line not idle high"); // R1

    AST_OE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> busy) else $error("drive outside exchange"); // R1

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> busy) else $error("start not taken"); // R8

    AST_BUSY_ENDS_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(|flag_set)) else $error("busy fell without flag"); // R8

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flag_set) <= 1) else $error("two outcomes at once"); // R5

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & ~flag_clr)) |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)))
        else $error("flag dropped without clear"); // R9
endmodule

bind sd_cmd_path sd_cmd_path_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .busy      (busy),
    .cmd_oe    (cmd_oe),
    .cmd_out   (cmd_out),
    .flags     (flags),
    .flag_clr  (flag_clr),
    .flag_set  (flag_set)
);

// File: tb/sd_cmd_path_bench.sv
module sd_cmd_path_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [1:0]  resp_kind = '0;
    logic [3:0]  flag_clr = '0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe, busy;
    logic [3:0]  flags;
    logic [5:0]  resp_index;
    logic [31:0] resp_word0, resp_word1, resp_word2, resp_word3;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sd_cmd_path u_sd_cmd_path (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .resp_kind(resp_kind), .flag_clr(flag_clr), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .flags(flags),
        .resp_index(resp_index), .resp_word0(resp_word0), .resp_word1(resp_word1),
        .resp_word2(resp_word2), .resp_word3(resp_word3)
    );

    // index, argument, expected frame (known-good CRC7 values)
    localparam logic [85:0] VEC [3] = '{
        {6'd0,  32'h0000_0000, 48'h4000_0000_0095},
        {6'd17, 32'h0000_0000, 48'h5100_0000_0055},
        {6'd8,  32'h0000_01AA, 48'h4800_0001_AA87}
    };

    localparam logic [47:0]  SHORT_GOOD = 48'h0800_0001_AA13;
    localparam logic [47:0]  SHORT_BAD  = 48'h0800_0001_AA15;
    localparam logic [127:0] LONG_PAY   = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk) flag_clr = 4'hF;
        @(negedge clk) flag_clr = 4'h0;
    endtask

    task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                            input bit poke, output logic [47:0] seen, output int oe_cnt);
        seen = '0;
        oe_cnt = 0;
        @(negedge clk);
        cmd_index = idx; cmd_arg = arg; resp_kind = kind; cmd_start = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            cmd_start = 1'b0;
            if (poke && i == 10) begin
                cmd_start = 1'b1; cmd_index = 6'd55; cmd_arg = 32'hFFFF_FFFF;
            end
            seen = {seen[46:0], cmd_out};
            if (cmd_oe) oe_cnt++;
        end
        cmd_start = 1'b0;
    endtask

    task automatic drive_resp(input logic [135:0] v, input int len, input int gap);
        for (int g = 0; g < gap; g++) @(negedge clk) cmd_in = 1'b1;
        for (int i = len - 1; i >= 0; i--) @(negedge clk) cmd_in = v[i];
        @(negedge clk) cmd_in = 1'b1;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] seen;
        int oe_cnt;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(flags == 0 && !busy && !cmd_oe && cmd_out && resp_index == 0 &&
            {resp_word0, resp_word1, resp_word2, resp_word3} == 0, "R10 reset", {flags, busy, cmd_oe, cmd_out}, 7'b0000001);
        @(negedge clk) rst_n = 1'b1;

        // R1/R3 table walk: frames with no reply expected
        for (int v = 0; v < 3; v++) begin
            send_cmd(VEC[v][85:80], VEC[v][79:48], (v == 1) ? 2'b10 : 2'b00, 1'b0, seen, oe_cnt);
            chk(seen == VEC[v][47:0] && oe_cnt == 48, "R1 frame", seen, VEC[v][47:0]);
            @(negedge clk);
            chk(flags == 4'b0001 && !busy, "R3 sent flag", {busy, flags}, 5'b00001);
            clear_all();
        end

        // R2 start during transmit ignored; R8 busy
        send_cmd(6'd8, 32'h1AA, 2'b00, 1'b1, seen, oe_cnt);
        chk(seen == 48'h4800_0001_AA87, "R2 frame kept", seen, 48'h4800_0001_AA87);
        @(negedge clk);
        chk(!busy && flags == 4'b0001, "R2 single exchange", {busy, flags}, 5'b00001);
        clear_all();

        // R4 short good reply
        send_cmd(6'd8, 32'h1AA, 2'b01, 1'b0, seen, oe_cnt);
        chk(busy, "R8 busy while waiting", busy, 1);
        drive_resp({88'b0, SHORT_GOOD}, 48, 0);
        chk(flags == 4'b0010, "R4 good flag", flags, 4'b0010);
        chk(resp_index == 6'd8 && resp_word0 == 32'h1AA && resp_word1 == 0, "R4 stored", {resp_index, resp_word0}, {6'd8, 32'h1AA});
        chk(!busy, "R8 busy falls", busy, 0);
        clear_all();

        // R5 short bad CRC
        send_cmd(6'd8, 32'h1AA, 2'b01, 1'b0, seen, oe_cnt);
        drive_resp({88'b0, SHORT_BAD}, 48, 0);
        chk(flags == 4'b0100, "R5 crc fail flag", flags, 4'b0100);
        chk(resp_index == 6'd8, "R5 index stored", resp_index, 6'd8);
        clear_all();

        // R5 short reply with end bit 0
        send_cmd(6'd8, 32'h1AA, 2'b01, 1'b0, seen, oe_cnt);
        drive_resp({88'b0, SHORT_GOOD[47:1], 1'b0}, 48, 0);
        chk(flags == 4'b0100, "R5 end bit", flags, 4'b0100);
        clear_all();

        // R6 long reply
        send_cmd(6'd2, 32'h0, 2'b11, 1'b0, seen, oe_cnt);
        drive_resp({2'b00, 6'h3F, LONG_PAY}, 136, 0);
        chk(flags == 4'b0010, "R6 long good", flags, 4'b0010);
        chk(resp_index == 6'h3F, "R6 long index", resp_index, 6'h3F);
        chk({resp_word0, resp_word1, resp_word2, resp_word3} == LONG_PAY, "R6 long words",
            {resp_word0, resp_word1, resp_word2, resp_word3}, LONG_PAY);
        clear_all();
        send_cmd(6'd2, 32'h0, 2'b11, 1'b0, seen, oe_cnt);
        drive_resp({2'b00, 6'h3F, LONG_PAY[127:1], 1'b0}, 136, 0);
        chk(flags == 4'b0100, "R6 long end bit", flags, 4'b0100);
        clear_all();

        // R7 timeout
        send_cmd(6'd9, 32'h0, 2'b01, 1'b0, seen, oe_cnt);
        repeat (64) @(negedge clk);
        chk(busy && flags == 0, "R7 still waiting at 64th cycle", {busy, flags}, 5'b10000);
        @(negedge clk);
        chk(flags == 4'b1000 && !busy, "R7 timeout", {busy, flags}, 5'b01000);
        // R9 sticky then cleared
        repeat (3) @(negedge clk);
        chk(flags == 4'b1000, "R9 sticky", flags, 4'b1000);
        @(negedge clk) flag_clr = 4'b1000;
        @(negedge clk) flag_clr = 4'b0000;
        chk(flags == 4'b0000, "R9 clear", flags, 4'b0000);

        // R7 start bit on the last allowed wait cycle
        send_cmd(6'd8, 32'h1AA, 2'b01, 1'b0, seen, oe_cnt);
        drive_resp({88'b0, SHORT_GOOD}, 48, 63);
        chk(flags == 4'b0010, "R7 late start accepted", flags, 4'b0010);
        clear_all();

        // R9 set and clear in the same cycle: set wins
        send_cmd(6'd9, 32'h0, 2'b01, 1'b0, seen, oe_cnt);
        repeat (63) @(negedge clk);
        @(negedge clk) flag_clr = 4'b1000;
        @(negedge clk) flag_clr = 4'b0000;
        chk(flags == 4'b1000, "R9 set wins over clear", flags, 4'b1000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule